// File: doc/BRIEF.md
# Infrared Mark/Space Envelope Sequencer

This block plays out a stream of timed commands as the on/off envelope of an infrared carrier. Software pushes 32-bit command words into a 128-deep queue. Each word names one of four timebases and a tick count. It also says whether the carrier passes to the output for that time (mark) or the output rests low (space). The carrier itself comes from outside as a square wave plus a one-cycle strobe per carrier period. The sequencer only gates that carrier.

Commands run strictly in queue order, back to back, with no dead cycle between them. A low-water comparator watches the queue level against a programmable threshold. When the level falls that far, a pending flag sets and can raise an interrupt, so software can top the queue up while it still plays. Software clears the flag by writing zero to it. A push into a full queue is thrown away and leaves a sticky overflow flag.

Top module: `irtx_seqr`

## Requirements
- R1: A write at address 0x8 pushes one command only when bit 16 of the written word is 1. A write at 0x8 with bit 16 clear, or a write at any other address with bit 16 set, leaves the queue level and the output unchanged.
- R2: Command bit 12 = 1 is a mark: `ir_o` follows `carrier_i` and `mark_o` is 1. Bit 12 = 0 is a space: `ir_o` and `mark_o` are 0.
- R3: Command bits 11:10 pick the timebase: 0 = 1 µs, 1 = 10 µs, 2 = 100 µs (one µs being `US_DIV` clock cycles). A command with count field d lasts exactly (d+1) timebase units, measured in clock cycles from the cycle it starts.
- R4: Timebase code 3 counts carrier periods. A command lasts until the (d+1)-th `car_tick_i` strobe, counting a strobe in its first cycle.
- R5: The count field is bits 9:0, so one command spans 1 to 1024 units. d = 1023 gives 1024 units.
- R6: Commands play in push order. Each new command starts in the cycle after the previous one ends.
- R7: With nothing left to play, `busy_o` falls in the cycle after the last command ends, and `ir_o` and `mark_o` rest at 0.
- R8: A push while the queue holds 128 commands is dropped: the level stays at 128, the command never plays, and `ovf_o` sets and stays set until reset.
- R9: Register 0xC holds the threshold in bits 6:0 and the interrupt enable in bit 8. While enabled, `pend_o` sets in the cycle after the level is at or below the threshold. While disabled, it never sets. `irq_o` equals `pend_o` AND the enable.
- R10: A write at 0xC with bit 16 = 0 clears `pend_o`. With bit 16 = 1 the flag is left as it was.
- R11: After reset, `busy_o`, `ir_o`, `mark_o`, `ovf_o`, `pend_o`, `irq_o` and `level_o` are all 0, and the interrupt is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the write |
| wdata_i | input | 32 | Write data |
| carrier_i | input | 1 | Carrier square wave |
| car_tick_i | input | 1 | One-cycle strobe per carrier period |
| ir_o | output | 1 | Modulated infrared drive |
| mark_o | output | 1 | Envelope: 1 while a mark plays |
| busy_o | output | 1 | A command is playing |
| level_o | output | 8 | Commands waiting in the queue |
| ovf_o | output | 1 | Sticky overflow flag |
| pend_o | output | 1 | Low-water pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The envelope is recorded as a list of runs, each with its length in cycles, its level and the carrier strobes inside it. This list is compared with the runs expected from each command set. The command sets used are an alternating mark/space mix across the three microsecond timebases, a maximum-count command, and a carrier-period timed pair; these separate timebase decoding, count off-by-one errors and gaps between commands. An overflow run starts one long mark and then fires 129 one-unit spaces, which all merge into a single space run; its length shows whether the dropped push played anyway. Threshold runs drain a short queue past the low-water mark with the enable on and then off, and write both values of the clear bit.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int CNT_W    = 10;
  localparam int PUSH_BIT = 16;
  localparam int MARK_BIT = 12;
  localparam int TB_LSB   = 10;
  localparam int IEN_BIT  = 8;
  localparam int PEND_BIT = 16;
  localparam logic [ADDR_W-1:0] CMD_ADDR = 4'h8;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 4'hC;

  typedef enum logic [1:0] {
    TB_1US   = 2'd0,
    TB_10US  = 2'd1,
    TB_100US = 2'd2,
    TB_CAR   = 2'd3
  } tbase_e;

  typedef struct packed {
    logic              mark;
    tbase_e            tb;
    logic [CNT_W-1:0]  cnt;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);

  function automatic cmd_t unpack_cmd(input logic [DATA_W-1:0] w);
    cmd_t c;
    c.mark = w[MARK_BIT];
    c.tb   = tbase_e'(w[TB_LSB+1:TB_LSB]);
    c.cnt  = w[CNT_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 13,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign level_o = lvl_q;
  assign rdata_o = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/irtx_tick.sv
module irtx_tick #(
  parameter int US_DIV = 250,
  localparam int PW    = (US_DIV > 1) ? $clog2(US_DIV) : 1,
  localparam int NDEC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  output logic [NDEC:0] tick_o
);
  logic [PW-1:0] pre_q;
  logic          t1;

  assign t1        = (pre_q == PW'(US_DIV-1));
  assign tick_o[0] = t1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else                pre_q <= t1 ? '0 : pre_q + 1'b1;
  end

  // decade stages: 10 us and 100 us, both counted in 1 us ticks
  for (genvar g = 0; g < NDEC; g++) begin : g_dec
    localparam int MOD = (g == 0) ? 10 : 100;
    localparam int CW  = $clog2(MOD);
    logic [CW-1:0] c_q;
    assign tick_o[g+1] = t1 && (c_q == CW'(MOD-1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        c_q <= '0;
      else if (restart_i) c_q <= '0;
      else if (t1)        c_q <= (c_q == CW'(MOD-1)) ? '0 : c_q + 1'b1;
    end
  end
endmodule

// File: rtl/irtx_play.sv
module irtx_play
  import irtx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       empty_i,
  input  cmd_t       cmd_i,
  input  logic [2:0] tick_i,
  input  logic       car_tick_i,
  output logic       pop_o,
  output logic       active_o,
  output logic       mark_o
);
  cmd_t             cur_q;
  logic [CNT_W-1:0] left_q;
  logic             act_q, step, expire;

  always_comb begin
    case (cur_q.tb)
      TB_1US:   step = tick_i[0];
      TB_10US:  step = tick_i[1];
      TB_100US: step = tick_i[2];
      default:  step = car_tick_i;
    endcase
  end

  assign expire   = act_q && step && (left_q == '0);
  assign pop_o    = !empty_i && (!act_q || expire);
  assign active_o = act_q;
  assign mark_o   = act_q && cur_q.mark;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cur_q  <= '0;
      left_q <= '0;
    end else if (pop_o) begin
      act_q  <= 1'b1;
      cur_q  <= cmd_i;
      left_q <= cmd_i.cnt;
    end else if (expire) begin
      act_q  <= 1'b0;
    end else if (act_q && step) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/irtx_seqr.sv
module irtx_seqr
  import irtx_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int US_DIV = 250,
  localparam int LW    = $clog2(DEPTH+1),
  localparam int TW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              carrier_i,
  input  logic              car_tick_i,
  output logic              ir_o,
  output logic              mark_o,
  output logic              busy_o,
  output logic [LW-1:0]     level_o,
  output logic              ovf_o,
  output logic              pend_o,
  output logic              irq_o
);
  logic          push_req, cfg_wr, fifo_full, fifo_empty, pop;
  logic [CMD_W-1:0] fifo_rd;
  logic [LW-1:0] level;
  logic [2:0]    ticks;
  logic          mark;
  logic [TW-1:0] thr_q, thr_n;
  logic          ien_q, ien_n, pend_q, pend_d, ovf_q, clr;
  cmd_t          push_cmd;

  assign push_req = wr_i && (addr_i == CMD_ADDR) && wdata_i[PUSH_BIT];
  assign cfg_wr   = wr_i && (addr_i == CFG_ADDR);
  assign push_cmd = unpack_cmd(wdata_i);

  irtx_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push_req),
    .wdata_i(push_cmd),
    .pop_i  (pop),
    .rdata_o(fifo_rd),
    .empty_o(fifo_empty),
    .full_o (fifo_full),
    .level_o(level)
  );

  irtx_tick #(.US_DIV(US_DIV)) u_tick (
    .clk_i, .rst_ni,
    .restart_i(pop),
    .tick_o   (ticks)
  );

  irtx_play u_play (
    .clk_i, .rst_ni,
    .empty_i   (fifo_empty),
    .cmd_i     (cmd_t'(fifo_rd)),
    .tick_i    (ticks),
    .car_tick_i(car_tick_i),
    .pop_o     (pop),
    .active_o  (busy_o),
    .mark_o    (mark)
  );

  // low-water pending: new cfg values take effect in the write cycle
  assign thr_n  = cfg_wr ? wdata_i[TW-1:0] : thr_q;
  assign ien_n  = cfg_wr ? wdata_i[IEN_BIT] : ien_q;
  assign clr    = cfg_wr && !wdata_i[PEND_BIT];
  assign pend_d = (pend_q && !clr) || (ien_n && (level <= LW'(thr_n)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      thr_q  <= thr_n;
      ien_q  <= ien_n;
      pend_q <= pend_d;
      if (push_req && fifo_full) ovf_q <= 1'b1;
    end
  end

  assign mark_o  = mark;
  assign ir_o    = mark && carrier_i;
  assign level_o = level;
  assign ovf_o   = ovf_q;
  assign pend_o  = pend_q;
  assign irq_o   = pend_q && ien_q;
endmodule

// File: rtl/irtx_seqr_chk.sv
module irtx_seqr_chk #(
  parameter int DEPTH = 128,
  parameter int LW    = 8,
  parameter int TW    = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          mark_o,
  input logic          ir_o,
  input logic          carrier_i,
  input logic [LW-1:0] level_o,
  input logic          ovf_o,
  input logic          pend_o,
  input logic          irq_o,
  input logic          push_req,
  input logic          fifo_full,
  input logic          cfg_wr,
  input logic          ien_q,
  input logic [TW-1:0] thr_q
);
  // R7
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mark_o && !ir_o));
  // R2
  gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_o |-> (mark_o && carrier_i));
  // R8
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_req && fifo_full) |=> ovf_o);
  // R8
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  // R8
  level_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));
  // R1
  no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_req |=> (level_o <= $past(level_o)));
  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o);
  // R9
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q && !cfg_wr && (level_o <= LW'(thr_q))) |=> pend_o);
endmodule

bind irtx_seqr irtx_seqr_chk #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) u_chk (
  .clk_i, .rst_ni, .busy_o, .mark_o, .ir_o, .carrier_i, .level_o,
  .ovf_o, .pend_o, .irq_o, .push_req, .fifo_full, .cfg_wr, .ien_q, .thr_q
);

// File: tb/tb_irtx_seqr.sv
`timescale 1ns/1ps
module tb_irtx_seqr;
  localparam int US  = 4;
  localparam int CPD = 5;

  logic        clk_i = 0, rst_ni = 0, wr_i = 0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        carrier_i, car_tick_i;
  logic        ir_o, mark_o, busy_o, ovf_o, pend_o, irq_o;
  logic [7:0]  level_o;

  int n_chk = 0, n_bad = 0;

  irtx_seqr #(.DEPTH(128), .US_DIV(US)) dut (.*);

  always #2 clk_i = ~clk_i;

  int car_cnt = 0;
  always @(posedge clk_i) car_cnt <= (car_cnt == CPD-1) ? 0 : car_cnt + 1;
  assign car_tick_i = (car_cnt == CPD-1);
  assign carrier_i  = (car_cnt < 2);

  // envelope run recorder
  int  nseg = 0, run_len = 0, run_tk = 0, ir_bad = 0;
  int  seg_len [32];
  int  seg_tk  [32];
  bit  seg_mk  [32];
  bit  pb = 0, pm = 0;

  task automatic store();
    if (nseg < 32) begin
      seg_len[nseg] = run_len; seg_tk[nseg] = run_tk; seg_mk[nseg] = pm;
    end
    nseg++; run_len = 0; run_tk = 0;
  endtask

  always @(negedge clk_i) begin
    if (busy_o) begin
      if (pb && mark_o != pm) store();
      run_len++;
      if (car_tick_i) run_tk++;
    end else if (pb) store();
    if (ir_o !== (mark_o & carrier_i)) ir_bad++;
    if (!mark_o && ir_o !== 1'b0) ir_bad++;
    pb = busy_o; pm = mark_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input bit mk, input int tb, input int d);
    return (32'd1 << 16) | (32'(mk) << 12) | (32'(tb) << 10) | 32'(d);
  endfunction

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 40000) begin @(negedge clk_i); n++; end
    @(negedge clk_i);
    chk(!busy_o, "R7 idle reached", busy_o, 0);
  endtask

  task automatic seg_chk(input int i, input bit mk, input int len, input string req);
    chk(seg_mk[i] == mk, req, seg_mk[i], mk);
    chk(seg_len[i] == len, req, seg_len[i], len);
  endtask

  task automatic t_reset();
    chk(!busy_o, "R11 busy", busy_o, 0);
    chk(!ir_o && !mark_o, "R11 out", ir_o, 0);
    chk(level_o == 0, "R11 level", level_o, 0);
    chk(!ovf_o, "R11 ovf", ovf_o, 0);
    chk(!pend_o && !irq_o, "R11 R9 pend disabled", pend_o, 0);
  endtask

  task automatic t_ignore();
    wreg(4'h8, 32'h0000_1005);
    wreg(4'h4, cmd(1, 0, 3));
    repeat (3) @(negedge clk_i);
    chk(level_o == 0, "R1 level", level_o, 0);
    chk(!busy_o, "R1 busy", busy_o, 0);
    chk(!mark_o && !ir_o, "R1 out", mark_o, 0);
  endtask

  task automatic t_basic();
    nseg = 0; ir_bad = 0;
    wreg(4'h8, cmd(1, 0, 2));
    wreg(4'h8, cmd(0, 0, 1));
    wreg(4'h8, cmd(1, 1, 1));
    wreg(4'h8, cmd(0, 2, 0));
    wait_idle();
    chk(nseg == 4, "R6 run count", nseg, 4);
    seg_chk(0, 1, 3*US,   "R3 R2 1us mark");
    seg_chk(1, 0, 2*US,   "R3 R6 1us space");
    seg_chk(2, 1, 20*US,  "R3 10us mark");
    seg_chk(3, 0, 100*US, "R3 100us space");
    chk(ir_bad == 0, "R2 gating", ir_bad, 0);
    chk(!mark_o && !ir_o, "R7 rest low", ir_o, 0);
  endtask

  task automatic t_long();
    nseg = 0;
    wreg(4'h8, cmd(1, 0, 1023));
    wreg(4'h8, cmd(0, 0, 0));
    wait_idle();
    chk(nseg == 2, "R5 run count", nseg, 2);
    seg_chk(0, 1, 1024*US, "R5 max count");
    seg_chk(1, 0, US, "R5 min count");
  endtask

  task automatic t_carrier();
    nseg = 0; ir_bad = 0;
    wreg(4'h8, cmd(1, 3, 3));
    wreg(4'h8, cmd(0, 3, 1));
    wait_idle();
    chk(nseg == 2, "R4 run count", nseg, 2);
    chk(seg_mk[0] && seg_tk[0] == 4, "R4 mark strobes", seg_tk[0], 4);
    chk(!seg_mk[1] && seg_tk[1] == 2, "R4 space strobes", seg_tk[1], 2);
    chk(seg_len[0] > 3*CPD && seg_len[0] <= 4*CPD, "R4 mark length", seg_len[0], 4*CPD);
    chk(ir_bad == 0, "R2 carrier gating", ir_bad, 0);
  endtask

  task automatic t_ovf();
    nseg = 0;
    wreg(4'h8, cmd(1, 2, 1));
    for (int i = 0; i < 128; i++) wreg(4'h8, cmd(0, 0, 0));
    chk(level_o == 128, "R8 full level", level_o, 128);
    chk(!ovf_o, "R8 no early ovf", ovf_o, 0);
    wreg(4'h8, cmd(0, 0, 0));
    chk(level_o == 128, "R8 drop level", level_o, 128);
    chk(ovf_o, "R8 ovf set", ovf_o, 1);
    wait_idle();
    chk(nseg == 2, "R8 run count", nseg, 2);
    seg_chk(0, 1, 200*US, "R8 long mark");
    seg_chk(1, 0, 128*US, "R8 dropped push not played");
    chk(ovf_o, "R8 sticky", ovf_o, 1);
  endtask

  task automatic t_thr();
    int n = 0;
    wreg(4'hC, (32'd1 << 16) | (32'd1 << 8) | 32'd2);
    @(negedge clk_i);
    chk(pend_o, "R9 pend at low level", pend_o, 1);
    chk(irq_o, "R9 irq", irq_o, 1);
    for (int i = 0; i < 4; i++) wreg(4'h8, cmd(0, 0, 7));
    chk(level_o == 3, "R9 level", level_o, 3);
    wreg(4'hC, (32'd1 << 8) | 32'd2);
    chk(!pend_o && !irq_o, "R10 clear by zero", pend_o, 0);
    wreg(4'hC, (32'd1 << 16) | (32'd1 << 8) | 32'd2);
    chk(!pend_o, "R10 one leaves flag", pend_o, 0);
    while (level_o > 2 && n < 1000) begin
      chk(!pend_o, "R9 no pend above threshold", pend_o, 0);
      @(negedge clk_i); n++;
    end
    @(negedge clk_i);
    chk(pend_o && irq_o, "R9 pend at threshold", pend_o, 1);
    wreg(4'hC, 32'd2);
    chk(!pend_o && !irq_o, "R9 R10 disable and clear", pend_o, 0);
    wait_idle();
    repeat (3) @(negedge clk_i);
    chk(!pend_o && !irq_o, "R9 disabled stays clear", pend_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_ignore();
    t_basic();
    t_long();
    t_carrier();
    t_ovf();
    t_thr();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule